// File: doc/BRIEF.md
# Digit-Serial Karatsuba Multiplier over GF(2^m)

This block multiplies two elements of the binary field GF(2^m). The field is fixed by an irreducible polynomial F(x) = x^m + K(x), and K(x) is a parameter. Both operands are cut into n digits of d bits, with m = n·d. Each digit is a polynomial in x, and the operand is a polynomial in y = x^d.

One cycle loads the operands. Each of the next n cycles takes one digit of B, starting with the lowest. That digit is multiplied against every digit of the running A register at once. Each digit product uses a one-level Karatsuba split into three half-size products. The (2d−1)-bit digit products are added into n accumulator digits. A is then advanced to A·y mod (y^n + K).

A final cycle folds the overlapping accumulator digits into one polynomial of m+d−1 bits. It reduces the part above x^(m−1) modulo F(x) and registers the m-bit result with a one-cycle done pulse. K(x) must have degree at most m−d, and m must be a multiple of d.

Top module: `gf2m_digit_kmul`

## Requirements
- R1: After an accepted start, c_out equals a_in·b_in mod F(x), where bit i of each vector is the coefficient of x^i and F(x) = x^M + TAPS.
- R2: done rises exactly N+1 rising edges after the edge that samples an accepted start, so an operation spans N+2 cycles counting the load cycle.
- R3: done is high for a single cycle per operation. busy is high from the edge after the start edge until the edge that raises done, and it is low while done is high.
- R4: A start asserted while busy is high is ignored: it adds no result, and its operands do not change the pending result.
- R5: c_out holds its value in every cycle in which done is low.
- R6: A start given in the cycle where done is high is accepted. The accumulator is cleared on every accepted start, so back-to-back results are independent.
- R7: While reset (rst, active high, synchronous) is applied, busy, done and c_out are all 0.
- R8: Boundary operands give exact results. A zero operand gives 0. The element 1 gives the other operand. x^(M−1)·x^(M−1) requires the reduction of the bits folded above digit N−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge active |
| rst | input | 1 | synchronous reset, active high |
| start | input | 1 | begin an operation when idle |
| a_in | input | M | first operand, bit i = coefficient of x^i |
| b_in | input | M | second operand, consumed one digit per cycle from the lowest |
| busy | output | 1 | operation in progress |
| done | output | 1 | one-cycle pulse, c_out just updated |
| c_out | output | M | product modulo F(x), held until the next done |

## Verification
The hardest case to reach is a large overflow above digit N−1 at the end of the loop. Only then does the final fold add a high-part product of K to the result. Random operands rarely set all the top coefficients at once. The stimulus therefore includes x^(M−1) squared and all-ones operands.

Ignored starts are sent in the middle of a run with different operands, and the result is compared with the first operands only. Some operations are issued in the same cycle as the previous done, so that any leftover accumulator content would show up in the result.

// File: rtl/gf2m_digit_kmul.sv
module gf2m_digit_kmul #(
  parameter int M = 12,
  parameter int D = 4,
  parameter logic [M-1:0] TAPS = 12'h009
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [M-1:0] a_in,
  input  logic [M-1:0] b_in,
  output logic         busy,
  output logic         done,
  output logic [M-1:0] c_out
);
  localparam int N  = M / D;
  localparam int H  = D / 2;
  localparam int L  = D - H;
  localparam int PW = 2*L - 1;
  localparam int DW = 2*D - 1;
  localparam int WW = M + D - 1;
  localparam int CW = $clog2(N + 1);
  localparam int LW = $clog2(N + 2) + 1;

  function automatic logic [PW-1:0] pmul(input logic [L-1:0] x, input logic [L-1:0] z);
    logic [PW-1:0] r;
    r = '0;
    for (int k = 0; k < L; k++)
      if (z[k]) r = r ^ (PW'(x) << k);
    return r;
  endfunction

  function automatic logic [DW-1:0] kmul(input logic [D-1:0] x, input logic [D-1:0] z);
    logic [L-1:0]  x0, z0, x1, z1;
    logic [PW-1:0] lo, hi, md;
    x0 = L'(x[H-1:0]);
    z0 = L'(z[H-1:0]);
    x1 = x[D-1:H];
    z1 = z[D-1:H];
    lo = pmul(x0, z0);
    hi = pmul(x1, z1);
    md = pmul(x0 ^ x1, z0 ^ z1);
    return DW'(lo) ^ (DW'(md ^ lo ^ hi) << H) ^ (DW'(hi) << (2*H));
  endfunction

  logic [M-1:0]  a_r, b_r, a_nx, c_nx;
  logic [DW-1:0] acc [N];
  logic [CW-1:0] cnt;
  logic [WW-1:0] wide;
  logic [LW-1:0] lat;

  always_comb begin
    a_nx = {a_r[M-D-1:0], {D{1'b0}}};
    for (int k = 0; k < D; k++)
      if (a_r[M-D+k]) a_nx = a_nx ^ (TAPS << k);
  end

  always_comb begin
    wide = '0;
    for (int j = 0; j < N; j++)
      wide = wide ^ (WW'(acc[j]) << (j*D));
    c_nx = wide[M-1:0];
    for (int k = 0; k < D-1; k++)
      if (wide[M+k]) c_nx = c_nx ^ (TAPS << k);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      c_out <= '0;
      cnt   <= '0;
      a_r   <= '0;
      b_r   <= '0;
      for (int j = 0; j < N; j++) acc[j] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          a_r  <= a_in;
          b_r  <= b_in;
          cnt  <= '0;
          busy <= 1'b1;
          for (int j = 0; j < N; j++) acc[j] <= '0;
        end
      end else if (cnt < CW'(N)) begin
        for (int j = 0; j < N; j++)
          acc[j] <= acc[j] ^ kmul(b_r[D-1:0], a_r[j*D +: D]);
        a_r <= a_nx;
        b_r <= b_r >> D;
        cnt <= cnt + 1'b1;
      end else begin
        c_out <= c_nx;
        done  <= 1'b1;
        busy  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lat <= '0;
    else if (start && !busy) lat <= '0;
    else if (busy) lat <= lat + 1'b1;
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> lat == LW'(N + 1));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R5
  hold_c_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(c_out) |-> done);

  // R4
  ignore_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !done) |=> (busy || done));
endmodule

// File: tb/sim_gf2m_digit_kmul.sv
module sim_gf2m_digit_kmul;
  localparam int M = 12;
  localparam int D = 4;
  localparam int N = M / D;
  localparam logic [M-1:0] TAPS = 12'h009;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [M-1:0] a_in = '0, b_in = '0;
  logic busy, done;
  logic [M-1:0] c_out;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 1'b0;
  logic [M-1:0] exp_q[$];
  int cyc_q[$];
  string tag_q[$];

  gf2m_digit_kmul #(.M(M), .D(D), .TAPS(TAPS)) u0 (
    .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
    .busy(busy), .done(done), .c_out(c_out));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] x, input logic [M-1:0] z);
    logic [M-1:0] r;
    r = '0;
    for (int i = M-1; i >= 0; i--) begin
      r = r[M-1] ? ((r << 1) ^ TAPS) : (r << 1);
      if (z[i]) r = r ^ x;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [M-1:0] act, input logic [M-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic drive(input logic [M-1:0] x, input logic [M-1:0] z, input string tag, input bit poke);
    @(negedge clk);
    while (busy) @(negedge clk);
    a_in = x; b_in = z; start = 1'b1;
    exp_q.push_back(ref_mul(x, z));
    cyc_q.push_back(cyc + N + 2);
    tag_q.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R3 busy after start", M'(busy), M'(1));
    if (poke) begin
      a_in = ~x; b_in = z ^ 12'h5a5; start = 1'b1;  // R4: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  logic [M-1:0] last_c = '0;
  bit prev_done = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected result", c_out, '0);
        end else begin
          logic [M-1:0] e;
          int ec;
          string t;
          e = exp_q.pop_front(); ec = cyc_q.pop_front(); t = tag_q.pop_front();
          chk(c_out === e, t, c_out, e);
          chk(cyc == ec, "R2 latency", M'(cyc), M'(ec));
          chk(busy === 1'b0, "R3 busy low at done", M'(busy), '0);
        end
        chk(!prev_done, "R3 done pulse width", M'(1), '0);
      end else if (c_out !== last_c) begin
        chk(1'b0, "R5 c_out changed without done", c_out, last_c);
      end
      last_c = c_out;
      prev_done = done;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R7 busy in reset", M'(busy), '0);
    chk(done === 1'b0, "R7 done in reset", M'(done), '0);
    chk(c_out === '0, "R7 c_out in reset", c_out, '0);
    @(negedge clk); rst = 1'b0;
    drive(12'h000, 12'h9c3, "R8 zero operand", 1'b0);
    drive(12'h001, 12'h9c3, "R8 one operand", 1'b0);
    drive(12'h7e4, 12'h001, "R8 one operand", 1'b0);
    drive(12'h800, 12'h800, "R8 top term squared", 1'b0);
    drive(12'hfff, 12'hfff, "R8 all ones", 1'b0);
    drive(12'h3a7, 12'h1c5, "R4 start while busy", 1'b1);
    drive(12'hb0d, 12'h0f1, "R4 start while busy", 1'b1);
    for (int i = 0; i < 60; i++)
      drive(M'($urandom), M'($urandom), "R6 back-to-back", 1'b0);
    for (int i = 0; i < 150; i++) begin
      drive(M'($urandom), M'($urandom), "R1 random product", i % 7 == 3);
      repeat (i % 3) @(negedge clk);
    end
    @(negedge clk);
    while (busy || exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule